// File: doc/BRIEF.md
# Selectable Serial Test Pattern Generator

This block drives a single serial line with a test bit stream picked by a 3-bit selector. The choices are three maximal-length pseudo-random sequences (orders 15, 20 and 23), a 20-bit sequence with long zero runs suppressed, a 0/1 toggle, constant ones, constant zeros, and a repeating 16-bit word loaded by software. Each control value is loaded through its own write strobe: the selector, the invert flag, the launch-edge flag and the user word. A write takes effect at the clock edge where the strobe is sampled.

The pattern state advances on every rising edge of the pattern clock. Each result bit is registered on the rising edge. With the edge flag set, that register drives the line directly. With the flag clear, the bit is re-captured on the falling edge, so the line changes half a cycle later and carries the same sequence. Writing a selector value that differs from the current one restarts the chosen pattern from its seed. Rewriting the same value leaves the pattern running.

Top module: `selpat_gen`

## Requirements
- R1: The reset is synchronous, active high, sampled on the rising edge. While it is applied, `dout` is 0. After reset the selector is 000, inversion is off, launch is on the rising edge and the user word is 0xDEAD. The first rising edge after release outputs bit 0 of the order-15 sequence.
- R2: Selector 000 gives the sequence of x^15+x^14+1. The register starts all ones, outputs its MSB, and shifts left with feedback MSB xor bit 13 entering at bit 0.
- R3: Selector 001 gives the sequence of x^20+x^3+1. The register starts all ones, outputs bit 19, and feeds back bit 19 xor bit 2.
- R4: Selector 011 gives the sequence of x^23+x^18+1. The register starts all ones, outputs bit 22, and feeds back bit 22 xor bit 17.
- R5: Selector 010 gives the R3 sequence, except that the output is forced to 1 whenever register bits 19 down to 6 are all zero. No zero run exceeds 14 bits.
- R6: Selector 100 outputs 0,1,0,1,... starting with 0.
- R7: Selector 101 outputs constant 1. Selector 110 outputs constant 0.
- R8: Selector 111 shifts out the user word MSB first, repeating every 16 bits.
- R9: With the invert flag set, every output bit is complemented. A flag write affects the bit launched at the following rising edge.
- R10: With the edge flag set, `dout` changes only just after rising edges. With it clear, `dout` changes just after falling edges and lags the same sequence by half a cycle.
- R11: A selector write with a new value, sampled at edge k, restarts the new pattern from its seed: bit 0 appears at edge k+1. Writing the value already held causes no restart.
- R12: A user-word write sampled at the same edge as a selector change to 111 is used from the first output bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pattern clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_wr | input | 1 | Write strobe for the selector |
| sel_in | input | 3 | Selector value |
| inv_wr | input | 1 | Write strobe for the invert flag |
| inv_in | input | 1 | Invert flag value |
| edge_wr | input | 1 | Write strobe for the launch-edge flag |
| edge_in | input | 1 | 1 = rising-edge launch, 0 = falling-edge launch |
| user_wr | input | 1 | Write strobe for the user word |
| user_in | input | 16 | User word value |
| dout | output | 1 | Serial test data |

## Verification
The case of interest is a pattern restart that falls in the same cycle as control updates. The bench changes the selector to 111 and loads a new user word in one write cycle. It also changes selector, invert and launch edge together. In both cases every bit from the first output onward must match a pattern computed from the seed with the new settings. It also rewrites the selector value already held and checks that the user pattern continues at the expected index rather than restarting.

// File: rtl/selpat_gen.sv
module selpat_gen #(
  parameter int              USER_W   = 16,
  parameter logic [USER_W-1:0] USER_RST = 16'hDEAD,
  parameter int              QRUN_MAX = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_wr,
  input  logic [2:0]        sel_in,
  input  logic              inv_wr,
  input  logic              inv_in,
  input  logic              edge_wr,
  input  logic              edge_in,
  input  logic              user_wr,
  input  logic [USER_W-1:0] user_in,
  output logic              dout
);
  localparam int IDX_W = $clog2(USER_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(USER_W - 1);
  localparam logic [2:0] SEL_P15  = 3'd0;
  localparam logic [2:0] SEL_P20  = 3'd1;
  localparam logic [2:0] SEL_QRS  = 3'd2;
  localparam logic [2:0] SEL_P23  = 3'd3;
  localparam logic [2:0] SEL_ALT  = 3'd4;
  localparam logic [2:0] SEL_ONE  = 3'd5;
  localparam logic [2:0] SEL_ZERO = 3'd6;

  logic [2:0]        sel_r;
  logic              inv_r, edge_r;
  logic [USER_W-1:0] user_r;
  logic [14:0]       p15;
  logic [19:0]       p20;
  logic [22:0]       p23;
  logic              alt_q;
  logic [IDX_W-1:0]  idx;
  logic              pos_q, neg_q, bit_raw;

  wire reload = sel_wr && (sel_in != sel_r);

  always_comb begin
    case (sel_r)
      SEL_P15:  bit_raw = p15[14];
      SEL_P20:  bit_raw = p20[19];
      SEL_QRS:  bit_raw = p20[19] | (p20[19:6] == '0);
      SEL_P23:  bit_raw = p23[22];
      SEL_ALT:  bit_raw = alt_q;
      SEL_ONE:  bit_raw = 1'b1;
      SEL_ZERO: bit_raw = 1'b0;
      default:  bit_raw = user_r[IDX_LAST - idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_r  <= SEL_P15;
      inv_r  <= 1'b0;
      edge_r <= 1'b1;
      user_r <= USER_RST;
      p15    <= '1;
      p20    <= '1;
      p23    <= '1;
      alt_q  <= 1'b0;
      idx    <= '0;
      pos_q  <= 1'b0;
    end else begin
      if (sel_wr)  sel_r  <= sel_in;
      if (inv_wr)  inv_r  <= inv_in;
      if (edge_wr) edge_r <= edge_in;
      if (user_wr) user_r <= user_in;
      pos_q <= bit_raw ^ inv_r;
      if (reload) begin
        p15   <= '1;
        p20   <= '1;
        p23   <= '1;
        alt_q <= 1'b0;
        idx   <= '0;
      end else begin
        p15   <= {p15[13:0], p15[14] ^ p15[13]};
        p20   <= {p20[18:0], p20[19] ^ p20[2]};
        p23   <= {p23[21:0], p23[22] ^ p23[17]};
        alt_q <= ~alt_q;
        idx   <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
      end
    end
  end

  always_ff @(negedge clk) begin
    if (rst) neg_q <= 1'b0;
    else     neg_q <= pos_q;
  end

  assign dout = edge_r ? pos_q : neg_q;

  logic [4:0] zrun;
  always_ff @(posedge clk) begin
    if (rst || reload || sel_r != SEL_QRS) zrun <= '0;
    else if (!bit_raw)                     zrun <= zrun + 1'b1;
    else                                   zrun <= '0;
  end

  AST_RESET_VALUES: assert property (@(posedge clk)
    rst |=> (sel_r == SEL_P15 && !inv_r && edge_r && user_r == USER_RST && !pos_q)); // R1
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
    (p15 != '0) && (p20 != '0) && (p23 != '0)); // R2 R3 R4
  AST_QRSS_RUN: assert property (@(posedge clk) disable iff (rst)
    zrun <= 5'(QRUN_MAX)); // R5
  AST_ALT_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (sel_r == SEL_ALT && !reload) |=> (bit_raw != $past(bit_raw))); // R6
  AST_ONES_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (sel_r == SEL_ONE && !inv_wr) |=> (pos_q == !inv_r)); // R7
  AST_ZERO_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (sel_r == SEL_ZERO && !inv_wr) |=> (pos_q == inv_r)); // R7
  AST_USER_FIRST: assert property (@(posedge clk) disable iff (rst)
    (reload && sel_in == 3'd7) |=> (bit_raw == user_r[USER_W-1])); // R8
endmodule

// File: tb/tb_selpat_gen.sv
module tb_selpat_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_wr = 1'b0, inv_wr = 1'b0, edge_wr = 1'b0, user_wr = 1'b0;
  logic [2:0] sel_in = 3'd0;
  logic inv_in = 1'b0, edge_in = 1'b1;
  logic [15:0] user_in = 16'h0;
  logic dout;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit exp_q[$];
  string tag_q[$];
  int zero_run = 0, max_run = 0;

  always #2 clk = ~clk;

  selpat_gen dut (.clk(clk), .rst(rst), .sel_wr(sel_wr), .sel_in(sel_in),
    .inv_wr(inv_wr), .inv_in(inv_in), .edge_wr(edge_wr), .edge_in(edge_in),
    .user_wr(user_wr), .user_in(user_in), .dout(dout));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_seq(input logic [2:0] s, input logic iv, input logic [15:0] uw,
                          input int start, input int n, input string tag);
    logic [14:0] r15 = '1;
    logic [19:0] r20 = '1;
    logic [22:0] r23 = '1;
    logic b;
    for (int i = 0; i < start + n; i++) begin
      case (s)
        3'd0: b = r15[14];
        3'd1: b = r20[19];
        3'd2: b = r20[19] | (r20[19:6] == '0);
        3'd3: b = r23[22];
        3'd4: b = i[0];
        3'd5: b = 1'b1;
        3'd6: b = 1'b0;
        default: b = uw[15 - (i % 16)];
      endcase
      if (i >= start) begin
        exp_q.push_back(b ^ iv);
        tag_q.push_back(tag);
      end
      r15 = {r15[13:0], r15[14] ^ r15[13]};
      r20 = {r20[18:0], r20[19] ^ r20[2]};
      r23 = {r23[21:0], r23[22] ^ r23[17]};
    end
  endtask

  task automatic write_cfg(input logic [2:0] s, input logic iv, input logic ed,
                           input bit wr_user, input logic [15:0] uw);
    @(negedge clk);
    sel_wr = 1'b1; sel_in = s;
    inv_wr = 1'b1; inv_in = iv;
    edge_wr = 1'b1; edge_in = ed;
    user_wr = wr_user; user_in = uw;
    @(posedge clk);
    @(negedge clk);
    sel_wr = 1'b0; inv_wr = 1'b0; edge_wr = 1'b0; user_wr = 1'b0;
    @(posedge clk);
  endtask

  task automatic edge_probe(input bit expect_change, input string tag);
    logic a, b;
    @(posedge clk);
    #1 a = dout;
    #2 b = dout;
    chk((a != b) == expect_change, tag, int'(a != b), int'(expect_change));
  endtask

  always @(posedge clk) begin
    bit e;
    string t;
    #3;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(dout === e, t, int'(dout), int'(e));
      if (t == "R5") begin
        zero_run = dout ? 0 : zero_run + 1;
        if (zero_run > max_run) max_run = zero_run;
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dout === 1'b0, "R1", int'(dout), 0);
    rst = 1'b0;
    @(posedge clk);
    push_seq(3'd0, 1'b0, 16'hDEAD, 0, 1, "R1");
    push_seq(3'd0, 1'b0, 16'hDEAD, 1, 120, "R2");
    wait (exp_q.size() == 0);

    write_cfg(3'd7, 1'b0, 1'b1, 1'b0, 16'h0);
    push_seq(3'd7, 1'b0, 16'hDEAD, 0, 32, "R1");
    wait (exp_q.size() == 0);

    write_cfg(3'd1, 1'b0, 1'b1, 1'b0, 16'h0);
    push_seq(3'd1, 1'b0, 16'h0, 0, 200, "R3");
    wait (exp_q.size() == 0);

    write_cfg(3'd3, 1'b0, 1'b1, 1'b0, 16'h0);
    push_seq(3'd3, 1'b0, 16'h0, 0, 200, "R4");
    wait (exp_q.size() == 0);

    write_cfg(3'd2, 1'b0, 1'b1, 1'b0, 16'h0);
    push_seq(3'd2, 1'b0, 16'h0, 0, 40000, "R5");
    wait (exp_q.size() == 0);
    chk(max_run <= 14, "R5", max_run, 14);

    write_cfg(3'd4, 1'b0, 1'b1, 1'b0, 16'h0);
    push_seq(3'd4, 1'b0, 16'h0, 0, 40, "R6");
    edge_probe(1'b0, "R10");
    wait (exp_q.size() == 0);

    write_cfg(3'd5, 1'b1, 1'b0, 1'b0, 16'h0);
    push_seq(3'd5, 1'b1, 16'h0, 0, 30, "R9");
    wait (exp_q.size() == 0);

    write_cfg(3'd4, 1'b0, 1'b0, 1'b0, 16'h0);
    push_seq(3'd4, 1'b0, 16'h0, 0, 40, "R10");
    edge_probe(1'b1, "R10");
    wait (exp_q.size() == 0);

    write_cfg(3'd5, 1'b0, 1'b1, 1'b0, 16'h0);
    push_seq(3'd5, 1'b0, 16'h0, 0, 20, "R7");
    wait (exp_q.size() == 0);

    write_cfg(3'd6, 1'b0, 1'b1, 1'b0, 16'h0);
    push_seq(3'd6, 1'b0, 16'h0, 0, 30, "R7");
    wait (exp_q.size() == 0);

    write_cfg(3'd7, 1'b0, 1'b1, 1'b1, 16'hA5C3);
    push_seq(3'd7, 1'b0, 16'hA5C3, 0, 40, "R12");
    wait (exp_q.size() == 0);

    write_cfg(3'd7, 1'b0, 1'b1, 1'b0, 16'h0);
    push_seq(3'd7, 1'b0, 16'hA5C3, 42, 40, "R11");
    wait (exp_q.size() == 0);

    write_cfg(3'd0, 1'b1, 1'b1, 1'b0, 16'h0);
    push_seq(3'd0, 1'b1, 16'h0, 0, 60, "R9");
    wait (exp_q.size() == 0);

    write_cfg(3'd7, 1'b0, 1'b1, 1'b1, 16'h0001);
    push_seq(3'd7, 1'b0, 16'h0001, 0, 48, "R8");
    wait (exp_q.size() == 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule